// File: doc/BRIEF.md
# Three-Digit Octal Entry Sequencer

This block turns three octal digits, typed one after another, into one 8-bit byte. A keypad front end supplies a 3-bit digit code with two strobes. The load strobe comes from the key press and writes the digit into the field chosen by an internal position counter. The step strobe comes from the key release and moves the counter on to the next field.

The fields are unequal and are filled most-significant first. The first digit fills the top two bits, so only digits 0 to 3 mean anything there. The second digit fills the middle three bits and the third fills the low three bits. Typing 3, 6 and 5 therefore gives octal 365 (0xF5).

After the third release the block raises a ready pulse of fixed length and goes back to the first position. A clear input returns the counter to the first position so that a wrong entry can be typed again. The byte stays on the output until a later load overwrites a field.

Top module: `octal_byte_sequencer`

## Requirements
- R1: While reset is low, and in the first cycle after it, byte_o is 0, ready_o is 0 and the next load writes the first field.
- R2: A load in the first position writes digit_i[1:0] into byte_o[7:6]. digit_i[2] is ignored and byte_o[5:0] keeps its value.
- R3: A load in the second position writes digit_i into byte_o[5:3]. A load in the third position writes digit_i into byte_o[2:0]. All other bits keep their value.
- R4: A load does not move the position, so repeated loads without a step overwrite the same field.
- R5: Each step moves the position from first to second to third. A step in the third position returns it to the first.
- R6: A step in the third position raises ready_o at the next clock edge and holds it high for exactly READY_CYCLES cycles. Steps in the first and second positions leave ready_o low.
- R7: Clear returns the position to the first field and takes priority over a step in the same cycle, so that step raises no ready pulse. Clear does not change byte_o.
- R8: byte_o holds its value in every cycle without a load, including while ready_o is high.
- R9: When load and step arrive in the same cycle, the load writes the field of the position held before the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| digit_i | input | 3 | Octal digit from the keypad |
| load_i | input | 1 | Key-press strobe: write the digit into the current field |
| step_i | input | 1 | Key-release strobe: advance the position |
| clear_i | input | 1 | Return the position to the first field |
| byte_o | output | 8 | Assembled byte |
| ready_o | output | 1 | Byte-complete pulse, READY_CYCLES cycles long |

## Verification
A load shows on byte_o at the clock edge that samples it. The effect of a step shows only through the next load, or through ready_o one edge after a third step. ready_o then stays high for READY_CYCLES edges. The bench drives every strobe on a falling edge and holds it for one cycle. It samples on the following falling edge, which comes after the one rising edge that registers the result. For the ready window it samples on READY_CYCLES successive falling edges and then on one more, where ready_o must be low. The sweep covers all 512 three-digit combinations, including first digits with bit 2 set.

// File: rtl/octkey_pkg.sv
// Shared constants and the position type for the octal entry sequencer.
package octkey_pkg;
    localparam int BYTE_W     = 8;   // assembled byte width
    localparam int DIGIT_W    = 3;   // width of one octal digit
    localparam int HI_W       = 2;   // width of the leading field
    localparam int NUM_FIELDS = 3;   // digits per byte

    // Entry position; SLOT_SPARE is never entered.
    typedef enum logic [1:0] {
        SLOT_HI    = 2'd0,
        SLOT_MID   = 2'd1,
        SLOT_LO    = 2'd2,
        SLOT_SPARE = 2'd3
    } slot_e;
endpackage

// File: rtl/octkey_slot_counter.sv
// Position counter: steps through the three entry positions on key release.
// Assumes step and clear are single-cycle strobes. Clear wins over step.
// wrap_o marks a step taken from the last position.
module octkey_slot_counter
    import octkey_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  step_i,
    input  logic  clear_i,
    output slot_e slot_o,
    output logic  wrap_o
);
    slot_e slot_q;
    slot_e slot_nxt;

    // Successor position for one step.
    always_comb begin
        case (slot_q)
            SLOT_HI:  slot_nxt = SLOT_MID;
            SLOT_MID: slot_nxt = SLOT_LO;
            default:  slot_nxt = SLOT_HI;
        endcase
    end

    // Position register with clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       slot_q <= SLOT_HI;
        else if (clear_i) slot_q <= SLOT_HI;
        else if (step_i)  slot_q <= slot_nxt;
    end

    assign slot_o = slot_q;
    assign wrap_o = step_i && !clear_i && (slot_q == SLOT_LO);
endmodule

// File: rtl/octkey_field_reg.sv
// Output byte register built from one field register per entry position.
// Each field loads from the low bits of the digit when its position is
// current and load is high. It holds otherwise.
module octkey_field_reg
    import octkey_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  slot_e              slot_i,
    input  logic [DIGIT_W-1:0] digit_i,
    output logic [BYTE_W-1:0]  byte_o
);
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
        localparam int W   = (g == 0) ? HI_W : DIGIT_W;
        localparam int LSB = BYTE_W - HI_W - g * DIGIT_W;
        logic [W-1:0] q;

        // Capture this field's digit bits on a load at its position.
        always_ff @(posedge clk) begin
            if (!rst_n)                                q <= '0;
            else if (load_i && slot_i == slot_e'(g))   q <= digit_i[W-1:0];
        end

        assign byte_o[LSB +: W] = q;
    end
endmodule

// File: rtl/octkey_ready_pulse.sv
// Fixed-length ready pulse generator. A fire strobe restarts the window,
// and ready stays high for READY_CYCLES cycles after the edge that saw it.
// Assumes READY_CYCLES >= 1.
module octkey_ready_pulse #(
    parameter int READY_CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic ready_o
);
    localparam int CNT_W = $clog2(READY_CYCLES + 1);
    logic [CNT_W-1:0] left_q;

    // Remaining high cycles; reloaded on fire, counted down otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)           left_q <= '0;
        else if (fire_i)      left_q <= CNT_W'(READY_CYCLES);
        else if (left_q != 0) left_q <= left_q - 1'b1;
    end

    assign ready_o = (left_q != 0);
endmodule

// File: rtl/octal_byte_sequencer.sv
// Three-digit octal entry sequencer: packs 2+3+3 bit fields MSB-first into
// one byte. Press writes the field, release advances the position, and the
// third release raises ready. Inputs are assumed synchronous and debounced.
module octal_byte_sequencer
    import octkey_pkg::*;
#(
    parameter int READY_CYCLES = 50
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIGIT_W-1:0] digit_i,
    input  logic               load_i,
    input  logic               step_i,
    input  logic               clear_i,
    output logic [BYTE_W-1:0]  byte_o,
    output logic               ready_o
);
    slot_e slot_q;
    logic  wrap;

    octkey_slot_counter u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (step_i),
        .clear_i (clear_i),
        .slot_o  (slot_q),
        .wrap_o  (wrap)
    );

    octkey_field_reg u_fields (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .slot_i  (slot_q),
        .digit_i (digit_i),
        .byte_o  (byte_o)
    );

    octkey_ready_pulse #(.READY_CYCLES(READY_CYCLES)) u_ready (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (wrap),
        .ready_o (ready_o)
    );
endmodule

// File: rtl/octkey_seq_checker.sv
// Property checker for octal_byte_sequencer, bound to the top module.
// It watches the ports and the position counter.
module octkey_seq_checker #(
    parameter int READY_CYCLES = 50
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] digit_i,
    input logic       load_i,
    input logic       step_i,
    input logic       clear_i,
    input logic [7:0] byte_o,
    input logic       ready_o,
    input logic [1:0] slot_i
);
    logic        fire;
    logic [31:0] run_q;

    assign fire = step_i && !clear_i && (slot_i == 2'd2);

    // Length of the current ready window, restarted by each fire.
    always_ff @(posedge clk) begin
        if (!rst_n)       run_q <= '0;
        else if (fire)    run_q <= '0;
        else if (ready_o) run_q <= run_q + 1;
        else              run_q <= '0;
    end

    AST_HI_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && slot_i == 2'd0 |=> byte_o[7:6] == $past(digit_i[1:0]) && byte_o[5:0] == $past(byte_o[5:0])); // R2
    AST_MID_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && slot_i == 2'd1 |=> byte_o[5:3] == $past(digit_i) && {byte_o[7:6], byte_o[2:0]} == $past({byte_o[7:6], byte_o[2:0]})); // R3
    AST_LO_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && slot_i == 2'd2 |=> byte_o[2:0] == $past(digit_i) && byte_o[7:3] == $past(byte_o[7:3])); // R3
    AST_LOAD_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && !step_i && !clear_i |=> slot_i == $past(slot_i)); // R4
    AST_STEP_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && !clear_i && slot_i < 2'd2 |=> slot_i == $past(slot_i) + 2'd1); // R5
    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> slot_i == 2'd0); // R5
    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        slot_i != 2'd3); // R5
    AST_READY_START: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> ready_o); // R6
    AST_READY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(fire)); // R6
    AST_READY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= READY_CYCLES); // R6
    AST_CLEAR_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> slot_i == 2'd0 && !$rose(ready_o)); // R7
    AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(byte_o)); // R8
endmodule

bind octal_byte_sequencer octkey_seq_checker #(.READY_CYCLES(READY_CYCLES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .digit_i (digit_i),
    .load_i  (load_i),
    .step_i  (step_i),
    .clear_i (clear_i),
    .byte_o  (byte_o),
    .ready_o (ready_o),
    .slot_i  (slot_q)
);

// File: tb/sim_octal_byte_sequencer.sv
// Bench: sweeps all three-digit entries, then directed clear, reset,
// repeat-load and same-cycle load/step cases.
module sim_octal_byte_sequencer;
    localparam int RC = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] digit = '0;
    logic       load = 1'b0;
    logic       step = 1'b0;
    logic       clear = 1'b0;
    logic [7:0] byte_w;
    logic       ready_w;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_b = '0;

    always #10 clk = ~clk;

    octal_byte_sequencer #(.READY_CYCLES(RC)) u0 (
        .clk(clk), .rst_n(rst_n), .digit_i(digit), .load_i(load),
        .step_i(step), .clear_i(clear), .byte_o(byte_w), .ready_o(ready_w)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One-cycle strobes driven on the falling edge; they return on the next falling edge.
    task automatic do_load(input logic [2:0] d);
        @(negedge clk); digit = d; load = 1'b1;
        @(negedge clk); load = 1'b0;
    endtask

    task automatic do_step();
        @(negedge clk); step = 1'b1;
        @(negedge clk); step = 1'b0;
    endtask

    task automatic do_both(input logic [2:0] d);
        @(negedge clk); digit = d; load = 1'b1; step = 1'b1;
        @(negedge clk); load = 1'b0; step = 1'b0;
    endtask

    // Ready must be high for RC samples, then low; byte must not move (R6, R8).
    task automatic ready_window();
        for (int k = 0; k <= RC; k++) begin
            chk("R6 ready window", 32'(ready_w), 32'(k < RC));
            chk("R8 byte held during ready", 32'(byte_w), 32'(exp_b));
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset byte", 32'(byte_w), 0);
        chk("R1 reset ready", 32'(ready_w), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 byte after reset", 32'(byte_w), 0);
        chk("R1 ready after reset", 32'(ready_w), 0);

        // Sweep all first, second and third digits, first digit bit 2 included.
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                for (int c = 0; c < 8; c++) begin
                    do_load(3'(a));
                    exp_b[7:6] = 2'(a);
                    chk("R2 first field", 32'(byte_w), 32'(exp_b));
                    do_step();
                    chk("R6 no ready after first step", 32'(ready_w), 0);
                    do_load(3'(b));
                    exp_b[5:3] = 3'(b);
                    chk("R3 second field", 32'(byte_w), 32'(exp_b));
                    do_step();
                    chk("R6 no ready after second step", 32'(ready_w), 0);
                    do_load(3'(c));
                    exp_b[2:0] = 3'(c);
                    chk("R3 third field", 32'(byte_w), 32'(exp_b));
                    do_step();
                    chk("R5 packed byte", 32'(byte_w), (a % 4) * 64 + b * 8 + c);
                    ready_window();
                end
            end
        end

        // R4: repeated loads without a step rewrite the first field.
        do_load(3'd1);
        do_load(3'd2);
        exp_b[7:6] = 2'd2;
        chk("R4 reload same field", 32'(byte_w), 32'(exp_b));
        do_step();
        do_load(3'd5);
        exp_b[5:3] = 3'd5;
        chk("R4 step then next field", 32'(byte_w), 32'(exp_b));
        do_step();
        do_load(3'd0);
        exp_b[2:0] = 3'd0;
        do_step();
        ready_window();

        // R7: clear with a step at the third position.
        do_load(3'd1); exp_b[7:6] = 2'd1; do_step();
        do_load(3'd7); exp_b[5:3] = 3'd7; do_step();
        @(negedge clk); clear = 1'b1; step = 1'b1;
        @(negedge clk); clear = 1'b0; step = 1'b0;
        chk("R7 clear blocks ready", 32'(ready_w), 0);
        chk("R7 clear keeps byte", 32'(byte_w), 32'(exp_b));
        repeat (2) @(negedge clk);
        chk("R8 idle hold", 32'(byte_w), 32'(exp_b));
        do_load(3'd2);
        exp_b[7:6] = 2'd2;
        chk("R7 restart at first field", 32'(byte_w), 32'(exp_b));
        do_step(); do_load(3'd3); exp_b[5:3] = 3'd3;
        do_step(); do_load(3'd4); exp_b[2:0] = 3'd4;
        do_step();
        ready_window();

        // R9: load and step together use the position held before the step.
        do_both(3'd3);
        exp_b[7:6] = 2'd3;
        chk("R9 combined load first field", 32'(byte_w), 32'(exp_b));
        chk("R9 no ready", 32'(ready_w), 0);
        do_load(3'd4);
        exp_b[5:3] = 3'd4;
        chk("R9 next load second field", 32'(byte_w), 32'(exp_b));
        do_step();
        do_both(3'd6);
        exp_b[2:0] = 3'd6;
        chk("R9 combined load third field", 32'(byte_w), 32'(exp_b));
        ready_window();

        // R1: reset in mid-entry clears the byte and the position.
        do_load(3'd1); do_step();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        exp_b = '0;
        chk("R1 mid-entry reset byte", 32'(byte_w), 0);
        do_load(3'd3);
        exp_b[7:6] = 2'd3;
        chk("R1 first field after reset", 32'(byte_w), 32'(exp_b));

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule